// File: doc/BRIEF.md
# LCD Pixel Format and Bus Packer

This block takes 32-bit words fetched from a frame buffer and turns them into pixels for a parallel RGB panel bus. Four static configuration inputs set how each word is read. A 2-bit word-length code and a 4-bit byte-valid mask choose between two 16-bit RGB565 pixels per word and one 24-bit pixel per word. A reduce flag trims 24-bit colour to 6 bits per component. A 2-bit bus code picks an 8, 16, 18 or 24 line output bus. Settings that cannot be served raise a configuration error, and the block then stays idle.

Words enter on a valid/ready stream and pixels leave on a valid/ready stream. The input side is back-pressured. `in_ready` is high only when the single holding register is empty, or when its last output beat is being accepted in the same cycle. The output side holds `pix_data` and `pix_valid` steady until `pix_ready` is seen. The pixel timing generator drives `pix_ready` once per pixel clock. A transfer happens on a rising `clk` edge where both valid and ready are high.

Top module: `lcd_pixel_packer`

## Requirements
- R1: With word-length code 0, mask 4'hF and a 16, 18 or 24 line bus, each word yields two RGB565 pixels (red 15:11, green 10:5, blue 4:0). Bits 15:0 go out first, then bits 31:16, each on pix_data[15:0].
- R2: With word-length code 3, mask 4'h7 and the reduce flag low, each word yields one pixel equal to word bits 23:0. Bits 31:24 have no effect.
- R3: With word-length code 3 and the reduce flag high, the components are red = word[21:16], green = word[13:8] and blue = word[5:0]. On an 18 or 24 line bus they are driven as pix_data[17:0] = {red, green, blue}.
- R4: With word-length code 3, the reduce flag high and a 16 line bus, the 6-6-6 pixel is driven on pix_data[15:0] as {red[5:1], green, blue[5:1]}.
- R5: With word-length code 0 on the 8 line bus, each word goes out as four byte beats on pix_data[7:0]: byte 0 (bits 7:0) first and byte 3 last.
- R6: Bus code 0 selects 16 lines, 1 selects 8, 2 selects 18 and 3 selects 24. Every pix_data bit above the selected width is zero.
- R7: cfg_err is high in any of these cases: the word-length code is 1 or 2; the mask does not match the code (4'hF for code 0, 4'h7 for code 3); 32-bit words are used with the 8 line bus; or 32-bit words are used with the reduce flag low on a 16 or 18 line bus. While cfg_err is high, in_ready and pix_valid stay low and input words are ignored.
- R8: in_ready is high only when no word is held, or when the held word's last beat is accepted in that same cycle.
- R9: While pix_valid is high and pix_ready is low, pix_valid and pix_data keep their values.
- R10: During reset pix_valid is low. With a legal configuration in_ready is high.
- R11: In 16-bit mode the reduce flag has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_len | input | 2 | Source word-length code (0 = 16-bit pixels, 3 = 32-bit words) |
| byte_mask | input | 4 | Valid bytes of each word |
| reduce18 | input | 1 | Drop 24-bit colour to 6 bits per component |
| bus_code | input | 2 | Output bus width code |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_word | input | 32 | Frame buffer word |
| pix_valid | output | 1 | Output beat valid |
| pix_ready | input | 1 | Output beat accepted when high with pix_valid |
| pix_data | output | 24 | Panel data bus, unused upper lines zero |
| cfg_err | output | 1 | Configuration cannot be served |

## Verification
The assertions assume that the four configuration inputs change only while the block holds no word. Under that assumption the held word, its beat index and the decoded beat count form a single consistent frame. The bench keeps to this rule. It changes configuration only after the last beat of the previous word has been taken and pix_valid has been observed low. It then sweeps every combination of word length, mask, reduce flag and bus code. For each legal combination it sends words with random top bytes and stalls every output beat for one cycle.

// File: rtl/lpp_pkg.sv
package lpp_pkg;
  localparam int WORD_W = 32;
  localparam int PIX_W  = 24;
  localparam int IDX_W  = 2;

  typedef enum logic [1:0] {
    BUS16 = 2'd0,
    BUS8  = 2'd1,
    BUS18 = 2'd2,
    BUS24 = 2'd3
  } bus_e;

  localparam logic [1:0] WL_HALF = 2'd0;
  localparam logic [1:0] WL_FULL = 2'd3;
  localparam logic [3:0] MASK_HALF = 4'hF;
  localparam logic [3:0] MASK_FULL = 4'h7;

  typedef struct packed {
    logic             err;
    logic             full_px;
    logic [IDX_W-1:0] last_idx;
  } plan_t;
endpackage

// File: rtl/lpp_cfg_decode.sv
module lpp_cfg_decode
  import lpp_pkg::*;
(
  input  logic [1:0] word_len,
  input  logic [3:0] byte_mask,
  input  logic       reduce18,
  input  logic [1:0] bus_code,
  output plan_t      plan
);
  logic half_ok, full_ok, narrow;

  always_comb begin
    half_ok = (word_len == WL_HALF) && (byte_mask == MASK_HALF);
    full_ok = (word_len == WL_FULL) && (byte_mask == MASK_FULL);
    narrow  = (bus_code == BUS16) || (bus_code == BUS18);
    plan.full_px = full_ok;
    plan.err = !(half_ok || full_ok)
             || (full_ok && bus_code == BUS8)
             || (full_ok && !reduce18 && narrow);
    if (full_ok)                 plan.last_idx = '0;
    else if (bus_code == BUS8)   plan.last_idx = IDX_W'(3);
    else                         plan.last_idx = IDX_W'(1);
  end
endmodule

// File: rtl/lpp_formatter.sv
module lpp_formatter
  import lpp_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [IDX_W-1:0]  idx,
  input  logic              full_px,
  input  logic              reduce18,
  input  logic [1:0]        bus_code,
  output logic [PIX_W-1:0]  pix
);
  localparam int NBYTES = WORD_W / 8;
  localparam int NHALF  = WORD_W / 16;

  logic [7:0]  byte_sel [NBYTES];
  logic [15:0] half_sel [NHALF];
  logic [5:0]  r6, g6, b6;

  genvar gi;
  generate
    for (gi = 0; gi < NBYTES; gi++) begin : g_bytes
      assign byte_sel[gi] = word[8*gi +: 8];
    end
    for (gi = 0; gi < NHALF; gi++) begin : g_halves
      assign half_sel[gi] = word[16*gi +: 16];
    end
  endgenerate

  always_comb begin
    r6  = word[21:16];
    g6  = word[13:8];
    b6  = word[5:0];
    pix = '0;
    if (!full_px) begin
      if (bus_code == BUS8) pix[7:0]  = byte_sel[idx];
      else                  pix[15:0] = half_sel[idx[0]];
    end else if (reduce18) begin
      if (bus_code == BUS16) pix[15:0] = {r6[5:1], g6, b6[5:1]};
      else                   pix[17:0] = {r6, g6, b6};
    end else begin
      pix = word[PIX_W-1:0];
    end
  end
endmodule

// File: rtl/lcd_pixel_packer.sv
module lcd_pixel_packer
  import lpp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  word_len,
  input  logic [3:0]  byte_mask,
  input  logic        reduce18,
  input  logic [1:0]  bus_code,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_word,
  output logic        pix_valid,
  input  logic        pix_ready,
  output logic [23:0] pix_data,
  output logic        cfg_err
);
  plan_t             plan;
  logic              held;
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;
  logic              last_beat, take_in, take_out;

  lpp_cfg_decode u_cfg (
    .word_len (word_len),
    .byte_mask(byte_mask),
    .reduce18 (reduce18),
    .bus_code (bus_code),
    .plan     (plan)
  );

  lpp_formatter u_fmt (
    .word    (word_q),
    .idx     (idx_q),
    .full_px (plan.full_px),
    .reduce18(reduce18),
    .bus_code(bus_code),
    .pix     (pix_data)
  );

  assign cfg_err   = plan.err;
  assign last_beat = (idx_q == plan.last_idx);
  assign pix_valid = held && !plan.err;
  assign take_out  = pix_valid && pix_ready;
  assign in_ready  = !plan.err && (!held || (last_beat && pix_ready));
  assign take_in   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held  <= 1'b0;
      idx_q <= '0;
    end else if (plan.err) begin
      held  <= 1'b0;
      idx_q <= '0;
    end else if (take_in) begin
      held  <= 1'b1;
      idx_q <= '0;
    end else if (take_out) begin
      if (last_beat) held <= 1'b0;
      else           idx_q <= idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take_in) word_q <= in_word;
  end

  // R9: a stalled beat keeps its value
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n || cfg_err)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_data));

  // R8: a new word enters only while the output side drains the last beat or is empty
  a_r8_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && held |-> pix_ready && last_beat);

  // R7: an illegal setting leaves nothing pending
  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !held);

  // R6: 8 line bus keeps upper lines low
  a_r6_zero_upper: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && bus_code == BUS8 |-> pix_data[23:8] == 16'h0);

  // R1: the first halfword of a packed pair is followed by the second
  a_r1_second_follows: assert property (@(posedge clk) disable iff (!rst_n || cfg_err)
    take_out && !last_beat |=> pix_valid);
endmodule

// File: tb/tb_lcd_pixel_packer.sv
module tb_lcd_pixel_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  word_len = 2'd0;
  logic [3:0]  byte_mask = 4'hF;
  logic        reduce18 = 1'b0;
  logic [1:0]  bus_code = 2'd0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = 32'h0;
  logic        pix_valid;
  logic        pix_ready = 1'b0;
  logic [23:0] pix_data;
  logic        cfg_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  lcd_pixel_packer dut (
    .clk(clk), .rst_n(rst_n), .word_len(word_len), .byte_mask(byte_mask),
    .reduce18(reduce18), .bus_code(bus_code), .in_valid(in_valid),
    .in_ready(in_ready), .in_word(in_word), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_data(pix_data), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h wl=%0d mask=%h red=%0d bus=%0d",
               req, act, exp, word_len, byte_mask, reduce18, bus_code);
    end
  endtask

  function automatic logic [31:0] next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed ^ (seed >> 13);
  endfunction

  function automatic int bus_lines(input logic [1:0] b);
    case (b)
      2'd0: return 16;
      2'd1: return 8;
      2'd2: return 18;
      default: return 24;
    endcase
  endfunction

  function automatic bit expect_err(input logic [1:0] wl, input logic [3:0] m,
                                    input logic r, input logic [1:0] b);
    bit h = (wl == 2'd0) && (m == 4'hF);
    bit f = (wl == 2'd3) && (m == 4'h7);
    if (!h && !f) return 1'b1;
    if (f && b == 2'd1) return 1'b1;
    if (f && !r && (b == 2'd0 || b == 2'd2)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [23:0] expect_pix(input logic [31:0] w, input int k);
    int rr, gg, bb;
    if (word_len == 2'd0) begin
      if (bus_code == 2'd1) return 24'((w >> (8*k)) & 32'hFF);
      return 24'((w >> (16*k)) & 32'hFFFF);
    end
    if (!reduce18) return w[23:0];
    rr = int'((w >> 16) % 64);
    gg = int'((w >> 8) % 64);
    bb = int'(w % 64);
    if (bus_code == 2'd0) return 24'((rr / 2) * 2048 + gg * 32 + bb / 2);
    return 24'(rr * 4096 + gg * 64 + bb);
  endfunction

  function automatic string tag_of();
    if (word_len == 2'd0 && bus_code == 2'd1) return "R5";
    if (word_len == 2'd0 && reduce18)          return "R11";
    if (word_len == 2'd0)                      return "R1";
    if (reduce18 && bus_code == 2'd0)          return "R4";
    if (reduce18)                              return "R3";
    return "R2";
  endfunction

  task automatic send_word(input logic [31:0] w, input int beats);
    logic [23:0] e;
    @(negedge clk);
    chk(in_ready === 1'b1, "R8", {31'h0, in_ready}, 32'h1);
    in_valid = 1'b1;
    in_word  = w;
    @(posedge clk);
    #1 in_valid = 1'b0;
    for (int k = 0; k < beats; k++) begin
      e = expect_pix(w, k);
      @(negedge clk);
      chk(pix_valid === 1'b1, "R9", {31'h0, pix_valid}, 32'h1);
      chk(pix_data === e, tag_of(), {8'h0, pix_data}, {8'h0, e});
      chk((32'(pix_data) >> bus_lines(bus_code)) == 32'h0, "R6", {8'h0, pix_data}, 32'h0);
      chk(in_ready === 1'b0, "R8", {31'h0, in_ready}, 32'h0);
      @(negedge clk);
      chk(pix_data === e && pix_valid === 1'b1, "R9", {8'h0, pix_data}, {8'h0, e});
      pix_ready = 1'b1;
      #1;
      chk(in_ready === (k == beats - 1), "R8", {31'h0, in_ready}, {31'h0, (k == beats - 1)});
      @(posedge clk);
      #1 pix_ready = 1'b0;
    end
    @(negedge clk);
    chk(pix_valid === 1'b0, "R8", {31'h0, pix_valid}, 32'h0);
  endtask

  initial begin : main
    bit e_err;
    int beats;
    repeat (3) @(negedge clk);
    chk(pix_valid === 1'b0, "R10", {31'h0, pix_valid}, 32'h0);
    chk(in_ready === 1'b1, "R10", {31'h0, in_ready}, 32'h1);
    rst_n = 1'b1;
    for (int wl = 0; wl < 4; wl++)
      for (int m = 0; m < 16; m++)
        for (int r = 0; r < 2; r++)
          for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            word_len = 2'(wl); byte_mask = 4'(m); reduce18 = r[0]; bus_code = 2'(b);
            e_err = expect_err(2'(wl), 4'(m), r[0], 2'(b));
            #1;
            chk(cfg_err === e_err, "R7", {31'h0, cfg_err}, {31'h0, e_err});
            if (e_err) begin
              in_valid = 1'b1; in_word = next_rand(); pix_ready = 1'b1;
              #1;
              chk(in_ready === 1'b0, "R7", {31'h0, in_ready}, 32'h0);
              @(negedge clk);
              chk(pix_valid === 1'b0, "R7", {31'h0, pix_valid}, 32'h0);
              in_valid = 1'b0; pix_ready = 1'b0;
            end else begin
              beats = (wl == 3) ? 1 : ((b == 1) ? 4 : 2);
              for (int n = 0; n < 2; n++) send_word(next_rand(), beats);
            end
          end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule